// File: doc/BRIEF.md
# Selectable Interrupt Source Controller

This block turns one of four event lines on the acquisition side of a data-capture card into a single active-low interrupt toward the host. A 3-bit select code picks the line. The selected line's qualifying edge is latched into a pending flag. The flag stays set until the host reads the acknowledge address.

There are two gates in the interrupt path. The local select code chooses which event can set the flag. A host-side enable, which starts out off, decides whether the flag drives the interrupt line. The host can always read the pending flag through the host-side register, even with the enable off. A driver on a shared interrupt line uses this bit to find out whether this device raised the request.

All event lines are sampled on the block clock. Every source is edge qualified on a high-to-low transition:

- The converter busy signal is low when idle. Its release marks the end of a conversion.
- The two pacer outputs and the external trigger are high when idle.

Top module: `irq_source_sel`

## Requirements
- R1: After reset the pending flag and the host enable are 0, `irq_n` is 1, and `host_rdata` reads 8'h00.
- R2: With `src_sel` = 3'b001, a high-to-low transition of `adc_busy` (end of conversion) sets the pending flag.
- R3: With `src_sel` = 3'b010, a high-to-low transition of `pacer0` sets the pending flag.
- R4: With `src_sel` = 3'b011, a high-to-low transition of `ext_trig` sets the pending flag.
- R5: With `src_sel` = 3'b100, a high-to-low transition of `pacer1` sets the pending flag.
- R6: Codes 3'b000, 3'b101, 3'b110 and 3'b111 select no source. Under these codes no line activity sets the pending flag. Under any code, activity on a line that is not selected does not set the flag.
- R7: A low-to-high transition on the selected line does not set the flag. A line that was already low when it became selected does not count as an edge.
- R8: A one-cycle `clr_rd` pulse clears the pending flag. If a qualifying event occurs in the same cycle as `clr_rd`, the flag stays set.
- R9: A host write (`host_wr`) loads the enable from `host_wdata[6]`. The enable reads back on `host_rdata[6]`.
- R10: `host_rdata[2]` reads the pending flag whatever the enable state. Writing `host_wdata[2]` has no effect on the flag.
- R11: `irq_n` is 0 exactly when both the pending flag and the enable are 1.
- R12: Changing `src_sel` does not clear a pending flag that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Local interrupt source code |
| adc_busy | input | 1 | Converter busy, high while converting |
| pacer0 | input | 1 | First pacer timer output |
| pacer1 | input | 1 | Second pacer timer output |
| ext_trig | input | 1 | External trigger input |
| clr_rd | input | 1 | One-cycle strobe: host read of the acknowledge address |
| host_wr | input | 1 | One-cycle strobe: host write of the host-side register |
| host_wdata | input | 8 | Host-side register write data (bit 6 = enable) |
| host_rdata | output | 8 | Host-side register readback (bit 6 = enable, bit 2 = pending) |
| irq_n | output | 1 | Host interrupt, active low |

## Verification
The assertions assume that all four event lines, the select code and both strobes are synchronous to `clk` and hold steady for whole cycles. They also assume that `clr_rd` and `host_wr` are single-cycle pulses. The bench meets these assumptions by changing every input on the falling clock edge and holding each level for at least one full cycle. Lines that are not selected are returned to their idle level before the next vector starts. This way, no edge left over from one vector is counted by the next one.

// File: rtl/irq_source_sel.sv
module irq_source_sel #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             adc_busy,
  input  logic             pacer0,
  input  logic             pacer1,
  input  logic             ext_trig,
  input  logic             clr_rd,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             irq_n
);

  localparam int EN_BIT   = 6;
  localparam int PEND_BIT = 2;
  localparam logic [3:0] IDLE = 4'b1110;

  // line order: {pacer1, ext_trig, pacer0, adc_busy}; every source fires on a falling edge
  logic [3:0] lines, prev_q, fell;
  logic       evt, pend_q, en_q;

  assign lines = {pacer1, ext_trig, pacer0, adc_busy};
  assign fell  = prev_q & ~lines;

  always_comb begin
    unique case (src_sel)
      3'd1:    evt = fell[0];
      3'd2:    evt = fell[1];
      3'd3:    evt = fell[2];
      3'd4:    evt = fell[3];
      default: evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      prev_q <= lines;
      if (evt)         pend_q <= 1'b1;
      else if (clr_rd) pend_q <= 1'b0;
      if (host_wr)     en_q <= host_wdata[EN_BIT];
    end
  end

  always_comb begin
    host_rdata           = '0;
    host_rdata[EN_BIT]   = en_q;
    host_rdata[PEND_BIT] = pend_q;
  end

  assign irq_n = ~(pend_q & en_q);

  assert_set_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> host_rdata[PEND_BIT]);

  assert_no_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && (src_sel == 3'd0 || src_sel > 3'd4)) |=> !pend_q);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !evt) |=> !host_rdata[PEND_BIT]);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_rd) |=> pend_q);

  assert_enable_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> host_rdata[EN_BIT] == $past(host_wdata[EN_BIT]));

  assert_gate_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> irq_n);

  assert_wdata_bit2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !evt && !clr_rd) |=> $stable(pend_q));

endmodule

// File: tb/irq_source_sel_tb.sv
`timescale 1ns/1ps
module irq_source_sel_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_sel = 3'd0;
  logic [3:0] lines;
  logic       clr_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       irq_n;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  localparam logic [3:0] IDLE = 4'b1110;

  always #4 clk = ~clk;

  irq_source_sel u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .adc_busy(lines[0]), .pacer0(lines[1]), .ext_trig(lines[2]), .pacer1(lines[3]),
    .clr_rd(clr_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_n(irq_n)
  );

  // {sel[5:3], line[2:1], expected pending[0]}; line 0 busy, 1 pacer0, 2 ext, 3 pacer1
  localparam logic [5:0] VEC [16] = '{
    {3'd1, 2'd0, 1'b1}, {3'd1, 2'd1, 1'b0},
    {3'd2, 2'd1, 1'b1}, {3'd2, 2'd0, 1'b0},
    {3'd3, 2'd2, 1'b1}, {3'd3, 2'd3, 1'b0},
    {3'd4, 2'd3, 1'b1}, {3'd4, 2'd2, 1'b0},
    {3'd0, 2'd0, 1'b0}, {3'd0, 2'd1, 1'b0},
    {3'd0, 2'd2, 1'b0}, {3'd0, 2'd3, 1'b0},
    {3'd5, 2'd1, 1'b0}, {3'd6, 2'd2, 1'b0},
    {3'd7, 2'd3, 1'b0}, {3'd7, 2'd0, 1'b0}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_line(input int l);
    lines = IDLE ^ (4'b0001 << l);
    cyc();
    lines = IDLE;
    cyc();
  endtask

  task automatic do_clear();
    clr_rd = 1'b1; cyc(); clr_rd = 1'b0; cyc();
  endtask

  task automatic host_write(input logic [7:0] d);
    host_wr = 1'b1; host_wdata = d; cyc(); host_wr = 1'b0; cyc();
  endtask

  initial begin
    lines = IDLE;
    repeat (3) cyc();
    check(host_rdata, 8'h00, "R1 readback");
    check({7'd0, irq_n}, 8'h01, "R1 irq_n");
    rst_n = 1'b1;
    cyc();
    check(host_rdata, 8'h00, "R1 after release");

    foreach (VEC[i]) begin
      src_sel = 3'd0;
      do_clear();
      src_sel = VEC[i][5:3];
      cyc();
      pulse_line(int'(VEC[i][2:1]));
      check({5'd0, host_rdata[2], 1'b0, irq_n}, {5'd0, VEC[i][0], 2'b01},
            $sformatf("R2/R3/R4/R5/R6 vector %0d", i));
    end

    // R7: rising edge of busy alone does not set; release does
    src_sel = 3'd0; do_clear(); src_sel = 3'd1; cyc();
    lines[0] = 1'b1; cyc(); cyc();
    check({7'd0, host_rdata[2]}, 8'h00, "R7 busy rising");
    lines[0] = 1'b0; cyc();
    check({7'd0, host_rdata[2]}, 8'h01, "R2 busy release");

    // R7: line already low when selected, then rises
    src_sel = 3'd0; lines[1] = 1'b0; cyc(); do_clear();
    src_sel = 3'd2; cyc(); cyc();
    check({7'd0, host_rdata[2]}, 8'h00, "R7 low when selected");
    lines[1] = 1'b1; cyc();
    check({7'd0, host_rdata[2]}, 8'h00, "R7 pacer0 rising");

    // R9 / R11: enable with pending set
    pulse_line(1);
    check({7'd0, irq_n}, 8'h01, "R11 pending but disabled");
    host_write(8'h43);
    check(host_rdata, 8'h44, "R9 enable readback");
    check({7'd0, irq_n}, 8'h00, "R11 line asserted");

    // R12: select change keeps flag
    src_sel = 3'd3; cyc(); src_sel = 3'd0; cyc();
    check({7'd0, host_rdata[2]}, 8'h01, "R12 select change");

    // R8: clear releases the line
    do_clear();
    check(host_rdata, 8'h40, "R8 clear");
    check({7'd0, irq_n}, 8'h01, "R11 released after clear");

    // R10: writing bit 2 does not set the flag
    host_write(8'h44);
    check(host_rdata, 8'h40, "R10 bit2 write ignored");

    // R8: event and clear in the same cycle keep flag set
    src_sel = 3'd2; cyc();
    lines[1] = 1'b0; clr_rd = 1'b1; cyc();
    clr_rd = 1'b0; lines[1] = 1'b1; cyc();
    check({7'd0, host_rdata[2]}, 8'h01, "R8 event wins over clear");

    // R9 / R10: disable, flag still visible
    host_write(8'h03);
    check(host_rdata, 8'h04, "R10 pending visible while disabled");
    check({7'd0, irq_n}, 8'h01, "R11 disabled line");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule